// File: doc/BRIEF.md
# Double-Buffered Configurable Serial Transmitter

This block serialises characters onto an asynchronous serial line. A host places one character at a time into a single-entry holding buffer; whenever the shift engine is free, the buffered character is moved into it and sent as a frame. That frame has a low start bit, 5 to 9 data bits with the least significant first, an optional even or odd parity bit, and one or two high stop bits. The line rests high between frames. Character size, parity and stop-bit count are sampled when a character is moved into the shift engine, so they can be changed between frames.

The bit period comes from a divisor: 16 × (divisor + 1) system clocks per bit, or 8 × (divisor + 1) when the double-speed input is high. For example, a 16 MHz clock with divisor 103 and normal speed gives 9600 bit/s. Two status outputs are kept apart. `buf_empty` says the holding buffer can take another character. `tx_done` says the last frame has fully left the line and nothing is waiting. The host clears `tx_done` by pulsing `done_clr`. Because of the holding buffer, the host can queue the next character while a frame is still on the line. Consecutive frames then follow with no idle time between them.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is a 0 start bit, then the data bits with the least significant first, then the parity bit when enabled, then the stop bits at 1. Between frames `txd` stays at 1.
- R3: `size_sel` sets the number of data bits: 3'b000 gives 5, 3'b001 gives 6, 3'b010 gives 7, 3'b011 gives 8 and 3'b111 gives 9. Every other code gives 8. The ninth data bit comes from `wr_bit8`, not from `wr_data`.
- R4: `par_sel` 2'b10 appends an even parity bit and 2'b11 appends an odd parity bit. In both cases the parity covers every data bit sent, including the ninth. Code 2'b00 sends no parity bit, and the reserved code 2'b01 behaves like 2'b00.
- R5: `stop2` at 0 sends one stop bit and `stop2` at 1 sends two.
- R6: Each bit lasts 16 × (`divisor` + 1) clocks when `dbl_speed` is 0 and 8 × (`divisor` + 1) clocks when it is 1.
- R7: A write (`wr_stb` high at a clock edge) makes `buf_empty` 0 after that edge. If the transmitter is idle and enabled, the next edge moves the character into the shift engine. After that edge `buf_empty` is 1 again and `txd` carries the start bit.
- R8: A write while `buf_empty` is 0 replaces the pending character, and only the newest character is sent.
- R9: If the buffer holds a character when the last stop bit ends, the next start bit begins on the very next clock. `buf_empty` rises on that same cycle and `tx_done` stays 0.
- R10: `tx_done` goes to 1 on the cycle after the last stop bit, and only when the buffer is empty. It holds until a `done_clr` pulse clears it.
- R11: While `tx_en` is 0, `txd` is 1 and no frame starts, but a pending character stays buffered. Dropping `tx_en` during a frame abandons that frame without setting `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| dbl_speed | input | 1 | Selects 8 instead of 16 clocks per divisor step |
| divisor | input | DIV_W | Bit-rate divisor |
| size_sel | input | 3 | Character size code |
| par_sel | input | 2 | Parity mode code |
| stop2 | input | 1 | Two stop bits when 1 |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Data bits 0 to 7 |
| wr_bit8 | input | 1 | Data bit 8 for 9-bit characters |
| done_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Frame finished and nothing pending |

## Verification
Every output is a register or a direct decode of registers. A write therefore shows as `buf_empty` low one clock after the strobe edge, and the start bit appears one clock after that. Bit k of a frame begins k × P clocks after the load edge, where P is the bit period, and `tx_done` rises exactly N × P clocks after the load edge for an N-bit frame. The bench counts falling clock edges from each write. It samples every bit at the middle of its period, which exposes any error in the bit period or bit order. It samples `tx_done` and the back-to-back start bit on the last clock of the final stop bit and on the clock after it, so an off-by-one in either direction fails a check.

// File: rtl/uart_tx_pkg.sv
// Package: shared constants, types and the character-size decode for the
// serial transmitter. Assumes at most 13 bits per frame (1+9+1+2).
package uart_tx_pkg;

    localparam int FRAME_MAX = 13;
    localparam int LEN_W     = 4;
    localparam int DATA_MAX  = 9;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [2:0] size_code;
        par_mode_e  par;
        logic       two_stop;
    } frame_cfg_t;

    // Maps the size code to a data-bit count; unlisted codes fall back to 8.
    function automatic logic [LEN_W-1:0] data_len(input logic [2:0] code);
        case (code)
            3'b000:  data_len = LEN_W'(5);
            3'b001:  data_len = LEN_W'(6);
            3'b010:  data_len = LEN_W'(7);
            3'b011:  data_len = LEN_W'(8);
            3'b111:  data_len = LEN_W'(9);
            default: data_len = LEN_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
// Bit-period timer: while run is high, raises tick on the last clock of every
// bit period of 16*(divisor+1) or 8*(divisor+1) clocks. Assumes divisor and
// dbl are held stable during a frame; the count restarts from zero whenever
// run is low.
module uart_tx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dbl,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 5;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] steps;
    logic [CNT_W-1:0] last_cnt;

    // Derive the final count value of one bit period.
    always_comb begin
        steps    = CNT_W'(divisor) + CNT_W'(1);
        last_cnt = (dbl ? (steps << 3) : (steps << 4)) - CNT_W'(1);
        tick     = run && (cnt >= last_cnt);
    end

    // Count clocks within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R6
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

endmodule

// File: rtl/uart_tx_hold.sv
// Holding buffer: one character entry written by the host and drained by the
// shift engine. A write always wins over a drain on the same edge, so a
// character written at the load edge stays pending.
module uart_tx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       wr_bit8,
    input  logic       take,
    output logic       full,
    output logic [8:0] data9
);
    // Capture host writes and release the entry when the engine takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            data9 <= '0;
        end else if (wr_stb) begin
            full  <= 1'b1;
            data9 <= {wr_bit8, wr_data};
        end else if (take) begin
            full  <= 1'b0;
        end
    end

    // R8
    hold_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (full && data9 == {$past(wr_bit8), $past(wr_data)}));

endmodule

// File: rtl/uart_tx_shift.sv
// Frame engine: builds the frame from the buffered character and the frame
// configuration, shifts it out one bit per tick, chains straight into a
// pending character, and keeps the clear-by-pulse completion flag. Assumes
// tick only occurs while busy is high.
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       have,
    input  logic [8:0] data9,
    input  frame_cfg_t cfg,
    input  logic       done_clr,
    output logic       busy,
    output logic       take,
    output logic       txd,
    output logic       done
);
    logic [FRAME_MAX-1:0] shreg;
    logic [FRAME_MAX-1:0] frame;
    logic [LEN_W-1:0]     left;
    logic [LEN_W-1:0]     flen;
    logic [LEN_W-1:0]     nd;
    logic                 par_bit;
    logic                 par_on;
    logic                 last;
    logic                 done_set;

    // Assemble start, data, optional parity and stop bits into one vector.
    always_comb begin
        nd      = data_len(cfg.size_code);
        par_on  = cfg.par[1];
        par_bit = (cfg.par == PAR_ODD);
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (LEN_W'(i) < nd) begin
                frame[i+1] = data9[i];
                par_bit    = par_bit ^ data9[i];
            end
        end
        if (par_on) begin
            frame[nd + LEN_W'(1)] = par_bit;
        end
        flen = LEN_W'(2) + nd + LEN_W'(par_on) + LEN_W'(cfg.two_stop);
    end

    // Decide when a new frame is loaded, either from idle or back to back.
    always_comb begin
        last     = (left == LEN_W'(1));
        take     = en && have && (!busy || (tick && last));
        done_set = en && busy && tick && last && !have;
        txd      = !(en && busy) || shreg[0];
    end

    // Load, shift and retire frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
        end else if (!en) begin
            busy  <= 1'b0;
        end else if (take) begin
            busy  <= 1'b1;
            shreg <= frame;
            left  <= flen;
        end else if (busy && tick) begin
            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
            left  <= left - LEN_W'(1);
            if (last) begin
                busy <= 1'b0;
            end
        end
    end

    // Hold the completion flag until the host pulses the clear input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (done_set) begin
            done <= 1'b1;
        end else if (done_clr) begin
            done <= 1'b0;
        end
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (shreg[0] == 1'b0));

    // R9
    chain_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && busy) |-> (tick && last));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left >= LEN_W'(1) && left <= LEN_W'(FRAME_MAX)));

endmodule

// File: rtl/uart_tx_dbuf.sv
// Top of the double-buffered serial transmitter: holding buffer, bit-period
// timer and frame engine. Frame configuration is sampled at each load.
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             dbl_speed,
    input  logic [DIV_W-1:0] divisor,
    input  logic [2:0]       size_sel,
    input  logic [1:0]       par_sel,
    input  logic             stop2,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic             wr_bit8,
    input  logic             done_clr,
    output logic             txd,
    output logic             buf_empty,
    output logic             tx_done
);
    logic       full;
    logic [8:0] data9;
    logic       take;
    logic       busy;
    logic       tick;
    frame_cfg_t cfg;

    // Pack the configuration pins into the shared frame type.
    always_comb begin
        cfg.size_code = size_sel;
        cfg.par       = par_mode_e'(par_sel);
        cfg.two_stop  = stop2;
        buf_empty     = !full;
    end

    uart_tx_hold i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .wr_bit8 (wr_bit8),
        .take    (take),
        .full    (full),
        .data9   (data9)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) i_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .dbl     (dbl_speed),
        .divisor (divisor),
        .tick    (tick)
    );

    uart_tx_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .tick     (tick),
        .have     (full),
        .data9    (data9),
        .cfg      (cfg),
        .done_clr (done_clr),
        .busy     (busy),
        .take     (take),
        .txd      (txd),
        .done     (tx_done)
    );

    // R11
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd);

    // R7
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !buf_empty);

    // R10
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> buf_empty);

endmodule

// File: tb/test_uart_tx_dbuf.sv
// Bench: sweeps all frame formats at a short bit period, then checks rates,
// chaining, overwrite, completion flag and enable behaviour.
module test_uart_tx_dbuf;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b1;
    logic dbl_speed = 1'b1;
    logic [DIV_W-1:0] divisor = '0;
    logic [2:0] size_sel = 3'b011;
    logic [1:0] par_sel = 2'b00;
    logic stop2 = 1'b0;
    logic wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic wr_bit8 = 1'b0;
    logic done_clr = 1'b0;
    logic txd, buf_empty, tx_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_dbuf #(.DIV_W(DIV_W)) i_uart_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dbl_speed(dbl_speed),
        .divisor(divisor), .size_sel(size_sel), .par_sel(par_sel),
        .stop2(stop2), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_bit8(wr_bit8), .done_clr(done_clr), .txd(txd),
        .buf_empty(buf_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input int code);
        case (code)
            0: return 5;
            1: return 6;
            2: return 7;
            3: return 8;
            7: return 9;
            default: return 8;
        endcase
    endfunction

    // Expected frame, bit 0 first on the line.
    task automatic make_frame(input int d9, input int code, input int pm,
                              input int two, output logic [12:0] f,
                              output int len);
        int nd;
        int p;
        int idx;
        nd = nbits(code);
        p = (pm == 3) ? 1 : 0;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[1+i] = 1'((d9 >> i) & 1);
            p = p ^ ((d9 >> i) & 1);
        end
        idx = 1 + nd;
        if (pm >= 2) begin
            f[idx] = 1'(p);
            idx++;
        end
        len = idx + ((two != 0) ? 2 : 1);
    endtask

    // Called on the first cycle of the start bit; returns on the last
    // cycle of the final stop bit.
    task automatic collect(input int per, input logic [12:0] f,
                           input int len, input string req);
        logic [12:0] got;
        got = '1;
        repeat (per/2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < len; k++) begin
            repeat (per) @(negedge clk);
            got[k] = txd;
        end
        chk(got == f, req, "frame bits", int'(got), int'(f));
        repeat (per/2 - 1) @(negedge clk);
        chk(tx_done == 1'b0 && txd == 1'b1, req, "last stop cycle done",
            int'(tx_done), 0);
    endtask

    task automatic pulse_clear;
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_char(input int d9);
        wr_stb  = 1'b1;
        wr_data = 8'(d9);
        wr_bit8 = 1'((d9 >> 8) & 1);
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic send_frame(input int d9, input int code, input int pm,
                              input int two, input int per, input string req);
        logic [12:0] f;
        int len;
        size_sel = 3'(code);
        par_sel  = 2'(pm);
        stop2    = 1'(two);
        pulse_clear();
        write_char(d9);
        chk(buf_empty == 1'b0, "R7", "buf_empty after write", int'(buf_empty), 0);
        @(negedge clk);
        chk(buf_empty == 1'b1 && txd == 1'b0, "R7", "load edge empty/start",
            int'({buf_empty, txd}), 2);
        make_frame(d9, code, pm, two, f, len);
        collect(per, f, len, req);
        @(negedge clk);
        chk(tx_done == 1'b1 && txd == 1'b1, "R10", "done after stop",
            int'(tx_done), 1);
    endtask

    task automatic measure_start(input int per);
        int cnt;
        size_sel = 3'b011;
        par_sel  = 2'b00;
        stop2    = 1'b0;
        write_char(9'h0FF);
        @(negedge clk);
        cnt = 0;
        while (txd == 1'b0 && cnt < 10000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == per, "R6", "start bit length", cnt, per);
        repeat (10 * per) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [12:0] fa;
        logic [12:0] fb;
        int la;
        int lb;
        bit all_high;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(txd == 1'b1 && buf_empty == 1'b1 && tx_done == 1'b0, "R1",
            "reset state", int'({txd, buf_empty, tx_done}), 6);

        // R2 R3 R4 R5: full format sweep with an 8-clock bit period.
        dbl_speed = 1'b1;
        divisor   = '0;
        foreach (fa[c]) begin end
        for (int ci = 0; ci < 6; ci++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    for (int v = 0; v < 2; v++) begin
                        int code;
                        int d9;
                        code = (ci == 5) ? 4 : ((ci == 4) ? 7 : ci);
                        d9 = ((v * 301) + (ci * 89) + (pm * 37) + (two * 151) + 90) & 9'h1FF;
                        send_frame(d9, code, pm, two, 8, "R2_R3_R4_R5");
                    end
                end
            end
        end

        // R6: bit periods for several divisor / speed settings.
        dbl_speed = 1'b0; divisor = 8'd0;
        measure_start(16);
        send_frame(9'h0A6, 3, 2, 0, 16, "R6");
        dbl_speed = 1'b0; divisor = 8'd2;
        measure_start(48);
        send_frame(9'h13C, 7, 3, 1, 48, "R6");
        dbl_speed = 1'b1; divisor = 8'd2;
        measure_start(24);
        send_frame(9'h019, 1, 0, 1, 24, "R6");

        // R9: back-to-back frames with no gap.
        dbl_speed = 1'b1; divisor = '0;
        size_sel = 3'b011; par_sel = 2'b00; stop2 = 1'b0;
        pulse_clear();
        make_frame(9'h0C3, 3, 0, 0, fa, la);
        make_frame(9'h05A, 3, 0, 0, fb, lb);
        write_char(9'h0C3);
        @(negedge clk);
        fork
            collect(8, fa, la, "R9");
            begin
                repeat (3) @(negedge clk);
                write_char(9'h05A);
                chk(buf_empty == 1'b0, "R9", "pending while busy", int'(buf_empty), 0);
            end
        join
        @(negedge clk);
        chk(txd == 1'b0 && buf_empty == 1'b1 && tx_done == 1'b0, "R9",
            "chained start", int'({txd, buf_empty, tx_done}), 2);
        collect(8, fb, lb, "R9");
        @(negedge clk);
        chk(tx_done == 1'b1, "R10", "done after chain", int'(tx_done), 1);

        // R10: flag holds until cleared.
        repeat (20) @(negedge clk);
        chk(tx_done == 1'b1, "R10", "done holds", int'(tx_done), 1);
        pulse_clear();
        chk(tx_done == 1'b0, "R10", "done cleared", int'(tx_done), 0);

        // R8: overwrite of a pending character.
        make_frame(9'h033, 3, 0, 0, fa, la);
        make_frame(9'h0E7, 3, 0, 0, fb, lb);
        write_char(9'h033);
        @(negedge clk);
        fork
            collect(8, fa, la, "R8");
            begin
                repeat (3) @(negedge clk);
                write_char(9'h0AA);
                write_char(9'h0E7);
            end
        join
        @(negedge clk);
        chk(txd == 1'b0, "R8", "second frame start", int'(txd), 0);
        collect(8, fb, lb, "R8");
        @(negedge clk);
        chk(tx_done == 1'b1 && buf_empty == 1'b1, "R8", "no third frame",
            int'({tx_done, buf_empty}), 3);
        pulse_clear();

        // R11: disabled transmitter holds the character.
        tx_en = 1'b0;
        write_char(9'h081);
        all_high = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) all_high = 0;
        end
        chk(all_high && buf_empty == 1'b0, "R11", "disabled idle, pending kept",
            int'({all_high, buf_empty}), 2);
        tx_en = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0 && buf_empty == 1'b1, "R11", "start after enable",
            int'({txd, buf_empty}), 1);
        make_frame(9'h081, 3, 0, 0, fa, la);
        collect(8, fa, la, "R11");
        @(negedge clk);
        chk(tx_done == 1'b1, "R11", "done after enabled frame", int'(tx_done), 1);
        pulse_clear();

        // R11: abort mid-frame.
        write_char(9'h000);
        @(negedge clk);
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R11", "line high on abort", int'(txd), 1);
        repeat (100) @(negedge clk);
        tx_en = 1'b1;
        all_high = 1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) all_high = 0;
        end
        chk(all_high && tx_done == 1'b0 && buf_empty == 1'b1, "R11",
            "aborted frame not resumed", int'({all_high, tx_done, buf_empty}), 5);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule